// File: doc/BRIEF.md
# BCD Alarm Comparator with Repeat Modes

The block watches a running calendar time, given as BCD seconds, minutes, hours and day-of-month, and compares it against four programmable alarm registers. Once per second an update strobe asks for a comparison. When the fields selected by the repeat setting all agree, the block raises an alarm flag. If software has enabled it, the block also raises an interrupt request.

Each alarm register carries one repeat bit in its most significant position. Together the four repeat bits choose how much of the time has to agree: nothing, the seconds alone, the minutes and seconds, the time of day, or the full date and time. Software clears the flag by reading the flags register. While the flags register address is held in the address latch, a new alarm event is kept back, so that a read in progress cannot swallow it. When the system runs from its backup supply, the interrupt needs a second enable.

Top module: `alarm_comparator`

## Requirements
- R1: After reset, alarm_flag and alarm_irq are 0 and all four alarm registers read back as 0x00.
- R2: A write with reg_wr high stores reg_wdata in the register chosen by reg_addr (0 seconds, 1 minutes, 2 hours, 3 date). reg_rdata shows the addressed register in the same cycle with no latency.
- R3: The repeat code is {date[7], hour[7], min[7], sec[7]}. The code picks the compared fields as follows: 1111 compares none, 1110 compares seconds, 1100 compares minutes and seconds, 1000 compares hours, minutes and seconds, and 0000 compares all four fields. The compared bits are sec[6:0], min[6:0], hour[5:0] and date[5:0].
- R4: Any repeat code outside the five listed in R3 compares no field, so every update strobe sets the flag.
- R5: A comparison is made only in a cycle with sec_tick high. A match there sets alarm_flag from the next clock edge on. Without sec_tick the flag never sets, even while the time keeps matching.
- R6: flag_rd high at a clock edge clears alarm_flag from that edge on. If a set and a read fall on the same edge, the set takes priority.
- R7: A match while flag_addr_sel is high does not set the flag. It is remembered instead, and the flag sets at the first clock edge where flag_addr_sel is low.
- R8: alarm_irq equals alarm_flag AND irq_en, further ANDed with batt_alarm_en while on_battery is high.
- R9: With all four alarm registers at 0x00, the alarm never fires for any valid time (date 01 to 31).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_sec | input | 8 | Running BCD seconds |
| time_min | input | 8 | Running BCD minutes |
| time_hour | input | 8 | Running BCD hours |
| time_date | input | 8 | Running BCD day of month |
| sec_tick | input | 1 | One-cycle update strobe, once per second |
| reg_wr | input | 1 | Alarm register write enable |
| reg_addr | input | 2 | Alarm register select |
| reg_wdata | input | 8 | Alarm register write data |
| reg_rdata | output | 8 | Addressed alarm register |
| flag_rd | input | 1 | Flags register read strobe |
| flag_addr_sel | input | 1 | Flags register address is latched |
| irq_en | input | 1 | Alarm interrupt enable |
| batt_alarm_en | input | 1 | Interrupt enable in battery mode |
| on_battery | input | 1 | System runs from backup supply |
| alarm_flag | output | 1 | Alarm flag |
| alarm_irq | output | 1 | Interrupt request |

## Verification
The bench targets several corner cases, each with a typical wrong design in mind.

- **Unlisted repeat codes.** A design that treated them as the full compare would stay silent where it should fire every second.
- **A mismatch in the date field alone under code 0000.** A decoder that dropped the date would fire each day.
- **A match with the flags address latched.** A design without the deferral would set the flag and then lose it on the following read. One that kept no record of the event would never set it at all.
- **A time that keeps matching across cycles with no strobe.** A level-sensitive comparator would set the flag again right after the read cleared it.
- **All-zero alarm registers and battery-mode gating.** These catch an alarm that cannot be turned off and an interrupt that leaks out while on the backup supply.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;

   localparam int unsigned NUM_FIELDS = 4;   // 0 sec, 1 min, 2 hour, 3 date
   localparam int unsigned FIELD_W    = 8;

   typedef logic [FIELD_W-1:0] field_t;

   // BCD bits that take part in the comparison for each field
   function automatic field_t cmp_mask(input int unsigned idx);
      return (idx < 2) ? 8'h7F : 8'h3F;
   endfunction

   // repeat code {date,hour,min,sec} -> fields to compare (bit i = field i)
   function automatic logic [NUM_FIELDS-1:0] fields_for(input logic [NUM_FIELDS-1:0] rpt);
      case (rpt)
         4'b1111: return 4'b0000;
         4'b1110: return 4'b0001;
         4'b1100: return 4'b0011;
         4'b1000: return 4'b0111;
         4'b0000: return 4'b1111;
         default: return 4'b0000;
      endcase
   endfunction

endpackage

// File: rtl/alarm_cmp_regs.sv
module alarm_cmp_regs
   import alarm_cmp_pkg::*;
#(
   parameter int unsigned ADDR_W = 2
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr,
   input  logic [ADDR_W-1:0]                  addr,
   input  field_t                             wdata,
   output field_t                             rdata,
   output logic [NUM_FIELDS-1:0][FIELD_W-1:0] regs
);

   localparam int unsigned SLOTS = 2 ** ADDR_W;

   generate
      if (SLOTS < NUM_FIELDS) begin : g_addr_check
         $error("alarm_cmp_regs: ADDR_W too small for the alarm fields");
      end
   endgenerate

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs[i] <= '0;
         else if (wr && (addr == ADDR_W'(i)))
            regs[i] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int j = 0; j < NUM_FIELDS; j++)
         if (addr == ADDR_W'(j)) rdata = regs[j];
   end

endmodule

// File: rtl/alarm_cmp_match.sv
module alarm_cmp_match
   import alarm_cmp_pkg::*;
(
   input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] alarm,
   input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] now,
   output logic                               hit
);

   logic [NUM_FIELDS-1:0] rpt;
   logic [NUM_FIELDS-1:0] eq;
   logic [NUM_FIELDS-1:0] use_f;

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
      localparam field_t MASK = cmp_mask(i);
      assign rpt[i] = alarm[i][FIELD_W-1];
      assign eq[i]  = ((alarm[i] ^ now[i]) & MASK) == '0;
   end

   assign use_f = fields_for(rpt);
   assign hit   = &(eq | ~use_f);

endmodule

// File: rtl/alarm_cmp_flag.sv
module alarm_cmp_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic hit,
   input  logic flag_rd,
   input  logic addr_sel,
   output logic flag,
   output logic pend
);

   logic event_now;
   logic set_now;

   assign event_now = tick && hit;
   assign set_now   = !addr_sel && (event_now || pend);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag <= 1'b0;
         pend <= 1'b0;
      end else begin
         if (set_now)
            flag <= 1'b1;
         else if (flag_rd)
            flag <= 1'b0;

         if (event_now && addr_sel)
            pend <= 1'b1;
         else if (!addr_sel)
            pend <= 1'b0;
      end
   end

endmodule

// File: rtl/alarm_comparator.sv
module alarm_comparator
   import alarm_cmp_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] time_sec,
   input  logic [DATA_W-1:0] time_min,
   input  logic [DATA_W-1:0] time_hour,
   input  logic [DATA_W-1:0] time_date,
   input  logic              sec_tick,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              flag_rd,
   input  logic              flag_addr_sel,
   input  logic              irq_en,
   input  logic              batt_alarm_en,
   input  logic              on_battery,
   output logic              alarm_flag,
   output logic              alarm_irq
);

   generate
      if (DATA_W != FIELD_W) begin : g_width_check
         $error("alarm_comparator: DATA_W must equal the BCD field width");
      end
   endgenerate

   logic [NUM_FIELDS-1:0][FIELD_W-1:0] alarm_regs;
   logic [NUM_FIELDS-1:0][FIELD_W-1:0] now;
   logic                               hit;
   logic                               pend_q;

   assign now = {time_date, time_hour, time_min, time_sec};

   alarm_cmp_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_wr),
      .addr  (reg_addr),
      .wdata (reg_wdata),
      .rdata (reg_rdata),
      .regs  (alarm_regs)
   );

   alarm_cmp_match u_match (
      .alarm (alarm_regs),
      .now   (now),
      .hit   (hit)
   );

   alarm_cmp_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (sec_tick),
      .hit      (hit),
      .flag_rd  (flag_rd),
      .addr_sel (flag_addr_sel),
      .flag     (alarm_flag),
      .pend     (pend_q)
   );

   assign alarm_irq = alarm_flag && irq_en && (!on_battery || batt_alarm_en);

endmodule

// File: rtl/alarm_cmp_checker.sv
module alarm_cmp_checker (
   input logic clk,
   input logic rst_n,
   input logic sec_tick,
   input logic flag_rd,
   input logic flag_addr_sel,
   input logic on_battery,
   input logic batt_alarm_en,
   input logic alarm_flag,
   input logic alarm_irq,
   input logic pend
);

   assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_irq |-> alarm_flag);

   assert_battery_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (on_battery && !batt_alarm_en) |-> !alarm_irq);

   assert_set_deferred_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_flag) |-> $past(!flag_addr_sel));

   assert_set_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_flag) |-> $past(sec_tick || pend));

   assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_rd && flag_addr_sel) |=> !alarm_flag);

endmodule

bind alarm_comparator alarm_cmp_checker u_alarm_cmp_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .sec_tick      (sec_tick),
   .flag_rd       (flag_rd),
   .flag_addr_sel (flag_addr_sel),
   .on_battery    (on_battery),
   .batt_alarm_en (batt_alarm_en),
   .alarm_flag    (alarm_flag),
   .alarm_irq     (alarm_irq),
   .pend          (pend_q)
);

// File: tb/test_alarm_comparator.sv
module test_alarm_comparator;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] time_sec = 8'h00, time_min = 8'h00, time_hour = 8'h00, time_date = 8'h01;
   logic       sec_tick = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       flag_rd = 1'b0, flag_addr_sel = 1'b0;
   logic       irq_en = 1'b0, batt_alarm_en = 1'b0, on_battery = 1'b0;
   logic       alarm_flag, alarm_irq;

   int checks = 0;
   int failures = 0;

   logic [7:0] m_reg [4];
   logic       m_flag = 1'b0;
   logic       m_pend = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alarm_comparator i_alarm_comparator (
      .clk(clk), .rst_n(rst_n),
      .time_sec(time_sec), .time_min(time_min), .time_hour(time_hour), .time_date(time_date),
      .sec_tick(sec_tick), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .flag_rd(flag_rd), .flag_addr_sel(flag_addr_sel),
      .irq_en(irq_en), .batt_alarm_en(batt_alarm_en), .on_battery(on_battery),
      .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
   );

   function automatic logic exp_match();
      logic [3:0] rpt;
      logic [3:0] sel;
      logic e0, e1, e2, e3;
      rpt = {m_reg[3][7], m_reg[2][7], m_reg[1][7], m_reg[0][7]};
      e0 = m_reg[0][6:0] == time_sec[6:0];
      e1 = m_reg[1][6:0] == time_min[6:0];
      e2 = m_reg[2][5:0] == time_hour[5:0];
      e3 = m_reg[3][5:0] == time_date[5:0];
      case (rpt)
         4'b1110: sel = 4'b0001;
         4'b1100: sel = 4'b0011;
         4'b1000: sel = 4'b0111;
         4'b0000: sel = 4'b1111;
         default: sel = 4'b0000;
      endcase
      return (!sel[0] || e0) && (!sel[1] || e1) && (!sel[2] || e2) && (!sel[3] || e3);
   endfunction

   function automatic logic exp_irq();
      return m_flag && irq_en && (!on_battery || batt_alarm_en);
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one clock: update the model from the inputs held across the edge, then sample at the falling edge
   task automatic step();
      logic ev;
      @(posedge clk);
      ev = sec_tick && exp_match();
      if (!rst_n) begin
         m_flag = 1'b0; m_pend = 1'b0;
         for (int k = 0; k < 4; k++) m_reg[k] = 8'h00;
      end else begin
         if (!flag_addr_sel && (ev || m_pend)) m_flag = 1'b1;
         else if (flag_rd) m_flag = 1'b0;
         if (ev && flag_addr_sel) m_pend = 1'b1;
         else if (!flag_addr_sel) m_pend = 1'b0;
         if (reg_wr) m_reg[reg_addr] = reg_wdata;
      end
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      step();
      reg_wr = 1'b0;
   endtask

   task automatic set_time(input logic [7:0] s, m, h, d);
      time_sec = s; time_min = m; time_hour = h; time_date = d;
   endtask

   task automatic tick_once();
      sec_tick = 1'b1; step(); sec_tick = 1'b0;
   endtask

   task automatic clear_flag();
      flag_addr_sel = 1'b1; flag_rd = 1'b1; step();
      flag_rd = 1'b0; flag_addr_sel = 1'b0; step();
   endtask

   function automatic logic [7:0] bcd(input int n);
      return 8'((n / 10) * 16 + (n % 10));
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [3:0] codes [8];
      codes = '{4'b1111, 4'b1110, 4'b1100, 4'b1000, 4'b0000, 4'b0101, 4'b0011, 4'b1010};
      void'($urandom(32'd20250417));

      // R1 reset state
      step(); step();
      rst_n = 1'b1;
      step();
      check("R1 flag", {7'd0, alarm_flag}, 8'd0);
      check("R1 irq", {7'd0, alarm_irq}, 8'd0);
      for (int k = 0; k < 4; k++) begin
         reg_addr = 2'(k); #1;
         check("R1 reg", reg_rdata, 8'h00);
      end

      // R9 all-zero alarm never fires
      set_time(8'h00, 8'h00, 8'h00, 8'h01);
      tick_once();
      set_time(8'h00, 8'h00, 8'h00, 8'h31);
      tick_once();
      check("R9 zero alarm", {7'd0, alarm_flag}, 8'd0);

      // R2 write / read back
      wr(2'd0, 8'hA5); wr(2'd1, 8'h3C); wr(2'd2, 8'h5A); wr(2'd3, 8'hC3);
      reg_addr = 2'd0; #1; check("R2 sec reg", reg_rdata, 8'hA5);
      reg_addr = 2'd1; #1; check("R2 min reg", reg_rdata, 8'h3C);
      reg_addr = 2'd2; #1; check("R2 hour reg", reg_rdata, 8'h5A);
      reg_addr = 2'd3; #1; check("R2 date reg", reg_rdata, 8'hC3);

      // R3 every minute: seconds only compared
      wr(2'd0, 8'h45); wr(2'd1, 8'h80 | 8'h10); wr(2'd2, 8'h80 | 8'h07); wr(2'd3, 8'h80 | 8'h09);
      set_time(8'h44, 8'h00, 8'h00, 8'h01);
      tick_once();
      check("R3 minute miss", {7'd0, alarm_flag}, 8'd0);
      set_time(8'h45, 8'h59, 8'h23, 8'h28);
      tick_once();
      check("R3 minute hit", {7'd0, alarm_flag}, 8'd1);
      clear_flag();
      check("R6 read clears", {7'd0, alarm_flag}, 8'd0);

      // R5 match held without strobe does not set again
      step(); step(); step();
      check("R5 no tick", {7'd0, alarm_flag}, 8'd0);

      // R3 once per month: a date mismatch alone blocks
      wr(2'd0, 8'h30); wr(2'd1, 8'h15); wr(2'd2, 8'h12); wr(2'd3, 8'h21);
      set_time(8'h30, 8'h15, 8'h12, 8'h22);
      tick_once();
      check("R3 month date miss", {7'd0, alarm_flag}, 8'd0);
      set_time(8'h30, 8'h15, 8'h12, 8'h21);
      tick_once();
      check("R3 month hit", {7'd0, alarm_flag}, 8'd1);
      clear_flag();

      // R4 unlisted code 0101 fires on every strobe
      wr(2'd0, 8'h80 | 8'h01); wr(2'd1, 8'h02); wr(2'd2, 8'h80 | 8'h03); wr(2'd3, 8'h04);
      set_time(8'h59, 8'h59, 8'h23, 8'h31);
      tick_once();
      check("R4 unlisted code", {7'd0, alarm_flag}, 8'd1);

      // R8 interrupt gating
      irq_en = 1'b0; #1; check("R8 irq disabled", {7'd0, alarm_irq}, 8'd0);
      irq_en = 1'b1; #1; check("R8 irq enabled", {7'd0, alarm_irq}, 8'd1);
      on_battery = 1'b1; #1; check("R8 battery blocked", {7'd0, alarm_irq}, 8'd0);
      batt_alarm_en = 1'b1; #1; check("R8 battery allowed", {7'd0, alarm_irq}, 8'd1);
      on_battery = 1'b0; batt_alarm_en = 1'b0;
      clear_flag();

      // R7 deferral while flags address latched
      flag_addr_sel = 1'b1;
      tick_once();
      step();
      check("R7 held back", {7'd0, alarm_flag}, 8'd0);
      flag_addr_sel = 1'b0;
      step();
      check("R7 released", {7'd0, alarm_flag}, 8'd1);

      // R6 set wins over a same-edge read
      flag_rd = 1'b1; sec_tick = 1'b1;
      step();
      flag_rd = 1'b0; sec_tick = 1'b0;
      check("R6 set priority", {7'd0, alarm_flag}, 8'd1);
      clear_flag();

      // random phase against the model
      for (int n = 0; n < 3000; n++) begin
         if ($urandom_range(0, 15) == 0) begin
            logic [3:0] c;
            c = codes[$urandom_range(0, 7)];
            reg_wr = 1'b1;
            reg_addr = 2'($urandom_range(0, 3));
            case (reg_addr)
               2'd0: reg_wdata = {c[0], bcd($urandom_range(0, 2))[6:0]};
               2'd1: reg_wdata = {c[1], bcd($urandom_range(0, 1))[6:0]};
               2'd2: reg_wdata = {c[2], 1'b0, bcd($urandom_range(0, 1))[5:0]};
               default: reg_wdata = {c[3], 1'b0, bcd($urandom_range(1, 2))[5:0]};
            endcase
         end else reg_wr = 1'b0;
         set_time(bcd($urandom_range(0, 2)), bcd($urandom_range(0, 1)),
                  bcd($urandom_range(0, 1)), bcd($urandom_range(1, 2)));
         sec_tick = ($urandom_range(0, 2) == 0);
         flag_addr_sel = ($urandom_range(0, 3) == 0);
         flag_rd = flag_addr_sel && ($urandom_range(0, 1) == 0);
         irq_en = $urandom_range(0, 1) == 1;
         on_battery = $urandom_range(0, 3) == 0;
         batt_alarm_en = $urandom_range(0, 1) == 1;
         step();
         check("R3/R5/R6/R7 random flag", {7'd0, alarm_flag}, {7'd0, m_flag});
         check("R8 random irq", {7'd0, alarm_irq}, {7'd0, exp_irq()});
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule